// File: doc/BRIEF.md
# Cascaded Multi-Bus Grant Allocator

This block hands out a set of parallel result/operand buses to function units in one cycle. Each function unit raises one bit of a unary request vector when it needs a bus, either to receive an operand or to send a result. The allocator answers with a one-hot grant vector for each bus, and each grant names a different unit.

The allocator is a chain of picker stages, one per bus. Each stage is a priority encoder that drives a decoder directly. The encoder finds the lowest-indexed unit still requesting. The decoder turns that index back into a one-hot grant. The winner is then cleared from the request vector before the next stage looks at it, so bus 0 goes to the lowest requester, bus 1 to the next one, and so on. Adding a bus adds one more stage to the chain.

The grants depend only on the current request vector. No state is held. Besides the per-bus grants, the block reports a valid flag and a binary unit index for each bus, the set of units granted any bus, and the number of buses in use.

Top module: `gnt_cascade`

## Requirements
- R1: Bus 0's grant is a one-hot vector whose single set bit is the lowest-indexed set bit of the request vector.
- R2: For bus k > 0, the grant is the lowest set bit of the request vector after the bits granted to buses 0..k-1 are cleared.
- R3: A bus with no remaining requester drives an all-zero grant, a deasserted valid flag and an index of 0.
- R4: A bus's valid flag is high exactly when its grant vector has a bit set.
- R5: No unit receives more than one bus in the same evaluation, and no unit that is not requesting is granted.
- R6: Each bus's index output is the binary position of its grant bit. Bus k occupies index bits [k*IW +: IW], where IW = $clog2(NUM_UNITS).
- R7: The granted-unit vector is the OR of all bus grants, and the count output equals min(popcount(request), NUM_BUSES).
- R8: Grants follow the request vector combinationally. No clock is involved, and a changed request is reflected without waiting for an edge.
- R9: When more units request than there are buses, the requesters with the highest indices go ungranted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_i | input | NUM_UNITS | Unary request vector, one bit per function unit |
| gnt_o | output | NUM_BUSES*NUM_UNITS | Per-bus one-hot grants; bus k occupies bits [k*NUM_UNITS +: NUM_UNITS] |
| gnt_vld_o | output | NUM_BUSES | Per-bus grant valid flag |
| gnt_idx_o | output | NUM_BUSES*$clog2(NUM_UNITS) | Per-bus binary index of the granted unit |
| unit_gnt_o | output | NUM_UNITS | Units holding any bus this cycle |
| gnt_cnt_o | output | $clog2(NUM_BUSES+1) | Number of buses granted |

## Verification
The hardest case to reach from the ports is the one where the chain runs dry part-way through. Here the early stages grant, a middle stage finds nothing left, and the later stages must stay idle instead of repeating an earlier winner. Random request words are therefore biased toward sparse vectors with one to NUM_BUSES-1 bits set. Directed vectors cover the all-zero, all-ones, single-top-bit and exactly-NUM_BUSES cases. The all-ones and dense random vectors also exercise the over-subscribed case, where the highest requesters must be left out.

// File: rtl/gnt_pkg.sv
package gnt_pkg;

  // Population count of a bus-valid vector, width-independent via int.
  function automatic int count_set(input logic [63:0] vec, input int width);
    int n;
    n = 0;
    for (int i = 0; i < width; i++) begin
      if (vec[i]) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/gnt_prio_enc.sv
module gnt_prio_enc #(
  parameter int NUM_UNITS = 8
) (
  input  logic [NUM_UNITS-1:0]         req_i,
  output logic [$clog2(NUM_UNITS)-1:0] idx_o,
  output logic                         found_o
);

  localparam int IW = $clog2(NUM_UNITS);

  // Scan from the top down so the lowest set bit is the last to write.
  always_comb begin
    idx_o   = '0;
    found_o = 1'b0;
    for (int i = NUM_UNITS - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o   = IW'(i);
        found_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/gnt_onehot_dec.sv
module gnt_onehot_dec #(
  parameter int NUM_UNITS = 8
) (
  input  logic [$clog2(NUM_UNITS)-1:0] idx_i,
  input  logic                         en_i,
  output logic [NUM_UNITS-1:0]         onehot_o
);

  always_comb begin
    onehot_o = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (en_i && (int'(idx_i) == i)) onehot_o[i] = 1'b1;
    end
  end

endmodule

// File: rtl/gnt_pick_stage.sv
module gnt_pick_stage #(
  parameter int NUM_UNITS = 8
) (
  input  logic [NUM_UNITS-1:0]         avail_i,
  output logic [NUM_UNITS-1:0]         gnt_o,
  output logic                         vld_o,
  output logic [$clog2(NUM_UNITS)-1:0] idx_o,
  output logic [NUM_UNITS-1:0]         remain_o
);

  logic [$clog2(NUM_UNITS)-1:0] enc_idx;
  logic                         enc_found;

  gnt_prio_enc #(.NUM_UNITS(NUM_UNITS)) u_enc (
    .req_i   (avail_i),
    .idx_o   (enc_idx),
    .found_o (enc_found)
  );

  gnt_onehot_dec #(.NUM_UNITS(NUM_UNITS)) u_dec (
    .idx_i    (enc_idx),
    .en_i     (enc_found),
    .onehot_o (gnt_o)
  );

  assign vld_o    = enc_found;
  assign idx_o    = enc_idx;
  assign remain_o = avail_i & ~gnt_o;

  always_comb begin
    if (!$isunknown(avail_i)) begin
      AST_STAGE_ONEHOT: assert ($onehot0(gnt_o)); // R1
      AST_STAGE_SUBSET: assert ((gnt_o & ~avail_i) == '0); // R5
      AST_STAGE_VLD: assert (vld_o == (gnt_o != '0)); // R4
      AST_STAGE_IDLE: assert ((avail_i != '0) || (!vld_o && idx_o == '0)); // R3
      AST_STAGE_LOWEST: assert (((gnt_o - 1'b1) & avail_i) == '0); // R2
    end
  end

endmodule

// File: rtl/gnt_cascade.sv
module gnt_cascade #(
  parameter int NUM_UNITS = 8,
  parameter int NUM_BUSES = 3
) (
  input  logic [NUM_UNITS-1:0]                   req_i,
  output logic [NUM_BUSES*NUM_UNITS-1:0]         gnt_o,
  output logic [NUM_BUSES-1:0]                   gnt_vld_o,
  output logic [NUM_BUSES*$clog2(NUM_UNITS)-1:0] gnt_idx_o,
  output logic [NUM_UNITS-1:0]                   unit_gnt_o,
  output logic [$clog2(NUM_BUSES+1)-1:0]         gnt_cnt_o
);

  localparam int IW = $clog2(NUM_UNITS);
  localparam int CW = $clog2(NUM_BUSES + 1);

  logic [NUM_UNITS-1:0] avail [NUM_BUSES+1];

  assign avail[0] = req_i;

  for (genvar k = 0; k < NUM_BUSES; k++) begin : g_stage
    gnt_pick_stage #(.NUM_UNITS(NUM_UNITS)) u_pick (
      .avail_i  (avail[k]),
      .gnt_o    (gnt_o[k*NUM_UNITS +: NUM_UNITS]),
      .vld_o    (gnt_vld_o[k]),
      .idx_o    (gnt_idx_o[k*IW +: IW]),
      .remain_o (avail[k+1])
    );
  end

  always_comb begin
    unit_gnt_o = '0;
    for (int k = 0; k < NUM_BUSES; k++) begin
      unit_gnt_o = unit_gnt_o | gnt_o[k*NUM_UNITS +: NUM_UNITS];
    end
  end

  always_comb begin
    gnt_cnt_o = CW'(gnt_pkg::count_set(64'(gnt_vld_o), NUM_BUSES));
  end

  always_comb begin
    if (!$isunknown(req_i)) begin
      AST_NO_DOUBLE_GRANT: assert ($countones(unit_gnt_o) == int'(gnt_cnt_o)); // R5
      AST_GRANT_IN_REQ: assert ((unit_gnt_o & ~req_i) == '0); // R5
      AST_CNT_CAP: assert (int'(gnt_cnt_o) == (($countones(req_i) < NUM_BUSES) ? $countones(req_i) : NUM_BUSES)); // R7
      AST_LEFTOVER_HIGH: assert ((avail[NUM_BUSES] == '0) || ((unit_gnt_o & ~((avail[NUM_BUSES] & -avail[NUM_BUSES]) - 1'b1)) == '0)); // R9
    end
  end

endmodule

// File: tb/gnt_cascade_bench.sv
module gnt_cascade_bench;

  localparam int NU = 8;
  localparam int NB = 3;
  localparam int IW = $clog2(NU);
  localparam int CW = $clog2(NB + 1);

  logic clk;
  logic [NU-1:0]    req;
  logic [NB*NU-1:0] gnt;
  logic [NB-1:0]    vld;
  logic [NB*IW-1:0] idx;
  logic [NU-1:0]    unit_gnt;
  logic [CW-1:0]    cnt;

  int tests;
  int fails;

  gnt_cascade #(.NUM_UNITS(NU), .NUM_BUSES(NB)) u_gnt_cascade (
    .req_i      (req),
    .gnt_o      (gnt),
    .gnt_vld_o  (vld),
    .gnt_idx_o  (idx),
    .unit_gnt_o (unit_gnt),
    .gnt_cnt_o  (cnt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h req=%0h", tag, act, exp, req);
    end
  endtask

  // Reference: walk the request bits from index 0 and hand out buses in order.
  task automatic check_now();
    logic [NU-1:0] eg [NB];
    logic [NU-1:0] eu;
    int ei [NB];
    int nxt;
    eu = '0;
    nxt = 0;
    for (int k = 0; k < NB; k++) begin
      eg[k] = '0;
      ei[k] = 0;
    end
    for (int i = 0; i < NU; i++) begin
      if (req[i] && nxt < NB) begin
        eg[nxt][i] = 1'b1;
        ei[nxt] = i;
        eu[i] = 1'b1;
        nxt++;
      end
    end
    for (int k = 0; k < NB; k++) begin
      chk(gnt[k*NU +: NU] == eg[k], (k == 0) ? "R1 bus0 grant" : "R2 bus grant",
          32'(gnt[k*NU +: NU]), 32'(eg[k]));
      chk(vld[k] == (eg[k] != '0), (eg[k] == '0) ? "R3 idle valid" : "R4 valid",
          32'(vld[k]), 32'(eg[k] != '0));
      chk(int'(idx[k*IW +: IW]) == ei[k], (eg[k] == '0) ? "R3 idle index" : "R6 index",
          32'(idx[k*IW +: IW]), 32'(ei[k]));
    end
    chk(unit_gnt == eu, "R7 unit grant", 32'(unit_gnt), 32'(eu));
    chk(int'(cnt) == nxt, "R7 count", 32'(cnt), 32'(nxt));
    chk($countones(unit_gnt) == int'(cnt), "R5 distinct", 32'($countones(unit_gnt)), 32'(cnt));
  endtask

  task automatic apply(input logic [NU-1:0] v);
    @(negedge clk);
    req = v;
    #1;
    check_now(); // R8: checked 1 ns after the change, well before any edge
  endtask

  initial begin
    tests = 0;
    fails = 0;
    req = '0;
    @(negedge clk);
    #1;
    chk(gnt == '0 && vld == '0, "R3 zero request", 32'(vld), 32'h0);
    apply('0);
    apply('1);
    chk(unit_gnt[NU-1:NB] == '0, "R9 top requesters dropped", 32'(unit_gnt), 32'((1 << NB) - 1));
    apply(NU'(1) << (NU - 1));
    apply(NU'(8'b1010_0100));
    apply(NU'(8'b0000_0011));
    apply(NU'(8'b1100_0000));
    apply(NU'(8'b1111_0000));
    chk(unit_gnt == NU'(8'b0111_0000), "R9 highest left out", 32'(unit_gnt), 32'h70);
    // R8: back-to-back changes in one phase, no edge between.
    @(negedge clk);
    req = NU'(8'b0001_0000);
    #1;
    req = NU'(8'b0000_0010);
    #1;
    chk(gnt[NU-1:0] == NU'(8'b0000_0010), "R8 combinational follow", 32'(gnt[NU-1:0]), 32'h2);
    void'($urandom(32'd1234));
    for (int n = 0; n < 400; n++) begin
      logic [NU-1:0] v;
      v = NU'($urandom);
      if (n % 2 == 0) v = v & NU'($urandom) & NU'($urandom);
      apply(v);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule